// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block gathers run-time statistics for a processor core. It holds one fixed counter and, by default, two programmable event counters. The fixed counter counts either every clock cycle or each pulse of a retired-instruction strobe. Each event counter counts the cycles in which one chosen line of a 64-wide event strobe bus is high. The core or other blocks produce the event strobes. This block only selects and counts them.

Each counter has its own control word. The control word holds an enable, an interrupt enable, two mode filters and a source select. One filter allows counting while the core runs privileged and the other while it runs unprivileged. When a counter wraps from all ones to zero it keeps counting. The wrap sets a sticky status bit, and software clears that bit by writing one to it. The interrupt request is high while any counter has both its status bit and its interrupt enable set.

Software reaches the block through a simple register port. Only privileged accesses take effect. An unprivileged write changes nothing and raises a one-cycle violation pulse. An unprivileged read returns zero.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset, every counter and every control word reads zero, and irq_o and acc_viol_o are low.
- R2: Counter k sits at address k, and its control word sits at address 8+k. Counter 0 is the fixed counter. Control bit 4 selects its source: 0 counts every clock cycle and 1 counts cycles with retire_i high.
- R3: An event counter's control bits [9:4] hold a select value s. The counter increments in each cycle where ev_i[s] is high. A value s at or above the number of event lines never counts.
- R4: Control bit 0 is the enable. While it is 0, the counter holds its value.
- R5: Control bit 2 allows counting while priv_i=1, and control bit 3 allows counting while priv_i=0. A counter increments only if the filter bit for the current mode is set.
- R6: An increment from all ones wraps the counter to zero. The counter keeps counting after the wrap, and the wrap sets the status bit, which reads at control bit 31.
- R7: Writing 1 to control bit 31 clears the status bit. Writing 0 there leaves it unchanged. If a wrap and a clear fall in the same cycle, the status bit ends up set.
- R8: irq_o is high exactly while some counter has its status bit set together with control bit 1, the interrupt enable.
- R9: A write with priv_i=0 changes no register, and acc_viol_o is high for the one cycle after it. A privileged write does not raise acc_viol_o.
- R10: Read data is valid in the same cycle as reg_en_i with reg_we_i=0. It is zero for unprivileged reads and for unmapped addresses.
- R11: A privileged write to a counter loads the low counter-width bits of reg_wdata_i. The write takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| priv_i | input | 1 | Current mode: 1 privileged, 0 user |
| ev_i | input | NUM_EVT | Event strobes |
| retire_i | input | 1 | Retired-instruction strobe |
| reg_en_i | input | 1 | Register access valid |
| reg_we_i | input | 1 | 1 write, 0 read |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data (combinational) |
| acc_viol_o | output | 1 | One-cycle pulse after an unprivileged write |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with CNT_W=8, NUM_EVT=64 and NUM_EV_CNT=2. The 8-bit counters can be preloaded near all ones, so a wrap, the sticky status bit and the interrupt are reached within a few cycles. The full 64-line event bus lets the bench select the highest event index, 63. A table of event-counter configurations walks through the select values and all the mode-filter combinations. Directed cases then cover the fixed counter's two sources, wrap during a status clear, unprivileged access, and a counter write that coincides with an increment.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 4;
  localparam int SEL_W     = 6;
  localparam int CTRL_BASE = 8;

  localparam int CB_EN  = 0;
  localparam int CB_IE  = 1;
  localparam int CB_SU  = 2;
  localparam int CB_US  = 3;
  localparam int CB_SEL = 4;
  localparam int CB_ST  = 31;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             cnt_us;
    logic             cnt_su;
    logic             irq_en;
    logic             en;
  } pmu_ctrl_t;

  function automatic pmu_ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
    pmu_ctrl_t c;
    c.en     = w[CB_EN];
    c.irq_en = w[CB_IE];
    c.cnt_su = w[CB_SU];
    c.cnt_us = w[CB_US];
    c.sel    = w[CB_SEL +: SEL_W];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_to_word(input pmu_ctrl_t c, input logic st);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CB_EN]              = c.en;
    w[CB_IE]              = c.irq_en;
    w[CB_SU]              = c.cnt_su;
    w[CB_US]              = c.cnt_us;
    w[CB_SEL +: SEL_W]    = c.sel;
    w[CB_ST]              = st;
    return w;
  endfunction
endpackage

// File: rtl/pmu_event_sel.sv
module pmu_event_sel
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 64
) (
  input  logic [NUM_EVT-1:0] ev_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               hit_o
);
  always_comb begin
    hit_o = 1'b0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (sel_i == SEL_W'(i)) hit_o = ev_i[i];
    end
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
  import pmu_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 64,
  parameter bit FIXED   = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              priv_i,
  input  logic [NUM_EVT-1:0] ev_i,
  input  logic              retire_i,
  input  logic              wr_cnt_i,
  input  logic              wr_ctrl_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] ctrl_word_o,
  output logic              st_o,
  output logic              ie_o,
  output logic              inc_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  pmu_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             st_q;
  logic             src_hit;
  logic             mode_ok;
  logic             wrap;
  logic             unused_bits;

  generate
    if (FIXED) begin : g_fixed
      assign src_hit     = ctrl_q.sel[0] ? retire_i : 1'b1;
      assign unused_bits = ^{ev_i, ctrl_q.sel[SEL_W-1:1], wdata_i};
    end else begin : g_event
      pmu_event_sel #(.NUM_EVT(NUM_EVT)) u_sel (
        .ev_i  (ev_i),
        .sel_i (ctrl_q.sel),
        .hit_o (src_hit)
      );
      assign unused_bits = ^{retire_i, wdata_i};
    end
  endgenerate

  assign mode_ok = priv_i ? ctrl_q.cnt_su : ctrl_q.cnt_us;
  assign inc_o   = ctrl_q.en & mode_ok & src_hit;
  assign wrap    = inc_o & ~wr_cnt_i & (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ctrl_q <= '0;
      st_q   <= 1'b0;
    end else begin
      if (wr_cnt_i)   cnt_q <= wdata_i[CNT_W-1:0];
      else if (inc_o) cnt_q <= cnt_q + 1'b1;
      if (wr_ctrl_i)  ctrl_q <= ctrl_from_word(wdata_i);
      // a wrap in the same cycle wins over a clear
      st_q <= wrap | (st_q & ~(wr_ctrl_i & wdata_i[CB_ST]));
    end
  end

  assign cnt_o       = cnt_q;
  assign st_o        = st_q;
  assign ie_o        = ctrl_q.irq_en;
  assign ctrl_word_o = ctrl_to_word(ctrl_q, st_q);
endmodule

// File: rtl/pmu_regif.sv
module pmu_regif
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 3,
  parameter int CNT_W   = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      priv_i,
  input  logic                      reg_en_i,
  input  logic                      reg_we_i,
  input  logic [ADDR_W-1:0]         reg_addr_i,
  input  logic [NUM_CNT*CNT_W-1:0]  cnt_flat_i,
  input  logic [NUM_CNT*DATA_W-1:0] ctrl_flat_i,
  output logic [NUM_CNT-1:0]        wr_cnt_o,
  output logic [NUM_CNT-1:0]        wr_ctrl_o,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      viol_o
);
  logic access;
  logic viol_q;

  assign access = reg_en_i & priv_i;

  always_comb begin
    wr_cnt_o  = '0;
    wr_ctrl_o = '0;
    rdata_o   = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      wr_cnt_o[k]  = access & reg_we_i & (reg_addr_i == ADDR_W'(k));
      wr_ctrl_o[k] = access & reg_we_i & (reg_addr_i == ADDR_W'(CTRL_BASE + k));
      if (access && !reg_we_i) begin
        if (reg_addr_i == ADDR_W'(k))
          rdata_o = DATA_W'(cnt_flat_i[k*CNT_W +: CNT_W]);
        if (reg_addr_i == ADDR_W'(CTRL_BASE + k))
          rdata_o = ctrl_flat_i[k*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_q <= 1'b0;
    else         viol_q <= reg_en_i & reg_we_i & ~priv_i;
  end

  assign viol_o = viol_q;
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
  import pmu_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int NUM_EVT    = 64,
  parameter int NUM_EV_CNT = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 priv_i,
  input  logic [NUM_EVT-1:0]   ev_i,
  input  logic                 retire_i,
  input  logic                 reg_en_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic                 acc_viol_o,
  output logic                 irq_o
);
  localparam int NUM_CNT = 1 + NUM_EV_CNT;

  logic [NUM_CNT*CNT_W-1:0]  cnt_flat;
  logic [NUM_CNT*DATA_W-1:0] ctrl_flat;
  logic [NUM_CNT-1:0]        wr_cnt_vec;
  logic [NUM_CNT-1:0]        wr_ctrl_vec;
  logic [NUM_CNT-1:0]        st_vec;
  logic [NUM_CNT-1:0]        ie_vec;
  logic [NUM_CNT-1:0]        inc_vec;

  pmu_regif #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_regif (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .priv_i      (priv_i),
    .reg_en_i    (reg_en_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .cnt_flat_i  (cnt_flat),
    .ctrl_flat_i (ctrl_flat),
    .wr_cnt_o    (wr_cnt_vec),
    .wr_ctrl_o   (wr_ctrl_vec),
    .rdata_o     (reg_rdata_o),
    .viol_o      (acc_viol_o)
  );

  generate
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
      pmu_counter #(
        .CNT_W   (CNT_W),
        .NUM_EVT (NUM_EVT),
        .FIXED   (k == 0)
      ) u_cnt (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .priv_i      (priv_i),
        .ev_i        (ev_i),
        .retire_i    (retire_i),
        .wr_cnt_i    (wr_cnt_vec[k]),
        .wr_ctrl_i   (wr_ctrl_vec[k]),
        .wdata_i     (reg_wdata_i),
        .cnt_o       (cnt_flat[k*CNT_W +: CNT_W]),
        .ctrl_word_o (ctrl_flat[k*DATA_W +: DATA_W]),
        .st_o        (st_vec[k]),
        .ie_o        (ie_vec[k]),
        .inc_o       (inc_vec[k])
      );
    end
  endgenerate

  assign irq_o = |(st_vec & ie_vec);
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
  import pmu_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_CNT = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     priv_i,
  input logic                     reg_en_i,
  input logic                     reg_we_i,
  input logic [ADDR_W-1:0]        reg_addr_i,
  input logic [DATA_W-1:0]        reg_wdata_i,
  input logic [DATA_W-1:0]        reg_rdata_o,
  input logic                     acc_viol_o,
  input logic                     irq_o,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  input logic [NUM_CNT-1:0]       st_vec,
  input logic [NUM_CNT-1:0]       inc_vec,
  input logic [NUM_CNT-1:0]       wr_cnt_vec
);
  localparam logic [CNT_W-1:0] ONES = '1;

  a_r8_irq_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (st_vec != '0));

  a_r9_user_write_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_en_i && reg_we_i && !priv_i) |=> acc_viol_o);

  a_r9_no_false_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_en_i && reg_we_i && !priv_i) |=> !acc_viol_o);

  a_r10_user_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_en_i && !priv_i) |-> (reg_rdata_o == '0));

  generate
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_chk
      a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!inc_vec[k] && !wr_cnt_vec[k]) |=> $stable(cnt_flat[k*CNT_W +: CNT_W]));

      a_r6_wrap_sets_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_vec[k] && !wr_cnt_vec[k] && cnt_flat[k*CNT_W +: CNT_W] == ONES)
        |=> (cnt_flat[k*CNT_W +: CNT_W] == '0 && st_vec[k]));

      a_r7_status_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_vec[k] && !(reg_en_i && reg_we_i && priv_i &&
          reg_addr_i == ADDR_W'(CTRL_BASE + k) && reg_wdata_i[CB_ST]))
        |=> st_vec[k]);

      a_r11_write_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_cnt_vec[k] |=> (cnt_flat[k*CNT_W +: CNT_W] == $past(reg_wdata_i[CNT_W-1:0])));
    end
  endgenerate
endmodule

bind perf_counter_unit pmu_checker #(.CNT_W(CNT_W), .NUM_CNT(NUM_CNT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .priv_i      (priv_i),
  .reg_en_i    (reg_en_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .acc_viol_o  (acc_viol_o),
  .irq_o       (irq_o),
  .cnt_flat    (cnt_flat),
  .st_vec      (st_vec),
  .inc_vec     (inc_vec),
  .wr_cnt_vec  (wr_cnt_vec)
);

// File: tb/perf_counter_unit_bench.sv
module perf_counter_unit_bench;
  localparam int CNT_W   = 8;
  localparam int NUM_EVT = 64;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               priv_i = 1'b1;
  logic [NUM_EVT-1:0] ev_i = '0;
  logic               retire_i = 1'b0;
  logic               reg_en_i = 1'b0;
  logic               reg_we_i = 1'b0;
  logic [3:0]         reg_addr_i = '0;
  logic [31:0]        reg_wdata_i = '0;
  logic [31:0]        reg_rdata_o;
  logic               acc_viol_o;
  logic               irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  perf_counter_unit #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .NUM_EV_CNT(2)) u_perf_counter_unit (
    .clk_i, .rst_ni, .priv_i, .ev_i, .retire_i, .reg_en_i, .reg_we_i,
    .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .acc_viol_o, .irq_o
  );

  typedef struct packed {
    logic [15:0] cfg;
    logic        priv;
    logic [5:0]  bit_idx;
    logic [7:0]  n;
    logic [7:0]  exp;
  } vec_t;

  // cfg: en=bit0 ie=bit1 su=bit2 us=bit3 sel=[9:4]
  localparam vec_t VECS [8] = '{
    '{16'h0055, 1'b1, 6'd5,  8'd7,  8'd7},
    '{16'h0055, 1'b1, 6'd6,  8'd7,  8'd0},
    '{16'h03FD, 1'b0, 6'd63, 8'd10, 8'd10},
    '{16'h0009, 1'b1, 6'd0,  8'd4,  8'd0},
    '{16'h0009, 1'b0, 6'd0,  8'd4,  8'd4},
    '{16'h021C, 1'b1, 6'd33, 8'd5,  8'd0},
    '{16'h0215, 1'b0, 6'd33, 8'd5,  8'd0},
    '{16'h011D, 1'b1, 6'd17, 8'd12, 8'd12}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    reg_en_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_en_i = 1'b0; reg_we_i = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    reg_en_i = 1'b1; reg_we_i = 1'b0; reg_addr_i = a;
    #1;
    d = reg_rdata_o;
    reg_en_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      rd_reg(4'(a), v); check("R1 counter", v, 0);
      rd_reg(4'(8 + a), v); check("R1 control", v, 0);
    end
    check("R1 irq", {31'b0, irq_o}, 0);
    check("R1 viol", {31'b0, acc_viol_o}, 0);

    // R3 R4 R5 table on counter 1
    for (int i = 0; i < 8; i++) begin
      priv_i = 1'b1;
      wr_reg(4'd9, {16'b0, VECS[i].cfg});
      wr_reg(4'd1, 32'd0);
      priv_i = VECS[i].priv;
      ev_i = NUM_EVT'(1) << VECS[i].bit_idx;
      repeat (int'(VECS[i].n)) @(negedge clk_i);
      ev_i = '0;
      priv_i = 1'b1;
      rd_reg(4'd1, v);
      check($sformatf("R3/R4/R5 vec%0d", i), v, {24'b0, VECS[i].exp});
    end

    // R2 fixed counter counting cycles
    wr_reg(4'd0, 32'd0);
    wr_reg(4'd8, 32'h5);
    repeat (6) @(negedge clk_i);
    rd_reg(4'd0, v); check("R2 cycles", v, 6);
    // R2 retire source
    wr_reg(4'd8, 32'h15);
    wr_reg(4'd0, 32'd0);
    for (int i = 0; i < 5; i++) begin
      retire_i = (i % 2 == 0);
      @(negedge clk_i);
    end
    retire_i = 1'b0;
    rd_reg(4'd0, v); check("R2 retire", v, 3);
    // R4 disable holds
    wr_reg(4'd8, 32'h0);
    retire_i = 1'b1;
    repeat (5) @(negedge clk_i);
    retire_i = 1'b0;
    rd_reg(4'd0, v); check("R4 hold", v, 3);

    // R6 wrap on counter 2
    wr_reg(4'd10, 32'h27);
    wr_reg(4'd2, 32'hFE);
    ev_i = NUM_EVT'(1) << 2;
    repeat (3) @(negedge clk_i);
    ev_i = '0;
    rd_reg(4'd2, v); check("R6 continues", v, 1);
    rd_reg(4'd10, v); check("R6 status", v, 32'h8000_0027);
    check("R8 irq set", {31'b0, irq_o}, 1);

    // R7 write 0 keeps, write 1 clears
    wr_reg(4'd10, 32'h27);
    rd_reg(4'd10, v); check("R7 write0 keeps", v, 32'h8000_0027);
    wr_reg(4'd10, 32'h8000_0027);
    rd_reg(4'd10, v); check("R7 write1 clears", v, 32'h27);
    check("R8 irq cleared", {31'b0, irq_o}, 0);

    // R7 wrap beats clear
    wr_reg(4'd2, 32'hFF);
    ev_i = NUM_EVT'(1) << 2;
    @(negedge clk_i);
    ev_i = '0;
    wr_reg(4'd2, 32'hFF);
    ev_i = NUM_EVT'(1) << 2;
    wr_reg(4'd10, 32'h8000_0027);
    ev_i = '0;
    rd_reg(4'd10, v); check("R7 set wins", v, 32'h8000_0027);
    rd_reg(4'd2, v); check("R6 wrapped", v, 0);

    // R8 interrupt gated by enable
    wr_reg(4'd10, 32'h8000_0025);
    wr_reg(4'd2, 32'hFF);
    ev_i = NUM_EVT'(1) << 2;
    @(negedge clk_i);
    ev_i = '0;
    rd_reg(4'd10, v); check("R8 status no ie", v, 32'h8000_0025);
    check("R8 irq gated", {31'b0, irq_o}, 0);
    wr_reg(4'd10, 32'h27);
    check("R8 irq enabled", {31'b0, irq_o}, 1);

    // R9 user write ignored
    priv_i = 1'b0;
    wr_reg(4'd1, 32'h55);
    check("R9 viol pulse", {31'b0, acc_viol_o}, 1);
    @(negedge clk_i);
    check("R9 viol one cycle", {31'b0, acc_viol_o}, 0);
    // R10 user read zero
    rd_reg(4'd1, v); check("R10 user read cnt", v, 0);
    rd_reg(4'd10, v); check("R10 user read ctrl", v, 0);
    priv_i = 1'b1;
    rd_reg(4'd1, v); check("R9 cnt untouched", v, 12);
    rd_reg(4'd15, v); check("R10 unmapped", v, 0);

    // R11 write beats increment
    ev_i = NUM_EVT'(1) << 17;
    wr_reg(4'd1, 32'h140);
    ev_i = '0;
    check("R9 no viol priv", {31'b0, acc_viol_o}, 0);
    rd_reg(4'd1, v); check("R11 write wins", v, 32'h40);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule